// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Threshold and Idle Timeout

This block holds the characters that a UART receiver deserializes until the host reads them. It has two modes. With the buffer-enable input low it is a single holding register, as in the classic non-buffered UART. With the input high it is a 16-entry first-in first-out queue. The host sees the oldest stored character on the read-data port at all times, and a read strobe removes that character.

In queue mode, two status signals help the host move data in bursts. The first, a threshold flag, is high while the number of stored characters is at or above a level picked by a 2-bit select. The second, an idle timeout, asserts when characters sit in the queue for four character times with no new arrival and no host read. Both flags are gated off in holding mode and when the receive interrupt enable is low (polled use). In those cases the host relies on the data-ready bit alone.

The data-ready bit is high whenever at least one character is stored. A character that arrives when no slot is free is discarded, and a one-cycle overrun pulse marks the loss. Any change of the mode input empties the buffer.

Top module: `uart_rx_fifo_trig`

## Requirements
- R1: After synchronous reset the buffer is empty and data_ready, trig_hit, timeout and overrun are all 0.
- R2: data_ready becomes 1 on the clock edge that stores a character and stays 1 until the edge that removes the last character. While it is 1, rd_data shows the oldest stored character.
- R3: With fifo_en=1 the buffer holds up to 16 characters and returns them in arrival order.
- R4: With fifo_en=0 the buffer holds one character. A character that arrives while that character is unread is discarded and the stored one is kept.
- R5: A character that arrives when no slot is free, with no read in the same cycle, is discarded. overrun is then 1 for exactly the following cycle.
- R6: trig_sel selects the threshold: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14. With fifo_en=1 and irq_en=1, trig_hit is 1 exactly while the stored count is at or above the threshold.
- R7: With fifo_en=1 and irq_en=1, timeout goes to 1 after 4 char_tick pulses seen while the buffer is non-empty with no store and no read. A store, a read, or the buffer emptying returns it to 0 and restarts the count.
- R8: When irq_en=0 or fifo_en=0, trig_hit and timeout are 0 whatever the fill level and the ticks.
- R9: A change of fifo_en in either direction empties the buffer on the next edge. Any store or read in that cycle is ignored.
- R10: A read strobe while empty has no effect. A store and a read in the same cycle on a full buffer are both carried out, so the count is unchanged and there is no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is on rx_data |
| rx_data | input | 8 | Received character |
| rd_strobe | input | 1 | Host read of the receive buffer; removes the oldest character |
| fifo_en | input | 1 | 1 = 16-deep queue, 0 = single holding register |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14) |
| irq_en | input | 1 | Receive interrupt enable; 0 means polled use |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Oldest stored character |
| data_ready | output | 1 | At least one character stored |
| trig_hit | output | 1 | Count at or above threshold |
| timeout | output | 1 | Idle timeout with characters pending |
| overrun | output | 1 | One-cycle pulse after a discarded character |

## Verification
The bench fills the queue to 16 and then offers a 17th character. A design that wraps the write pointer here would overwrite the oldest entry instead of pulsing overrun. It offers a store and a read together on a full buffer, where an ordering error drops the character. It sweeps all four thresholds across the boundary count, which exposes off-by-one comparisons. It waits exactly three and then four idle ticks, which exposes a timeout one tick early or late. It also toggles the mode with data present; a design that failed to flush would keep returning stale characters.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DEPTH      = 16;
    localparam int RXQ_DW         = 8;
    localparam int RXQ_IDLE_CHARS = 4;
    localparam int RXQ_CW         = $clog2(RXQ_DEPTH + 1);

    typedef enum logic [1:0] {
        THR_1  = 2'd0,
        THR_4  = 2'd1,
        THR_8  = 2'd2,
        THR_14 = 2'd3
    } thr_sel_e;

    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic drop;
    } rxq_move_t;

    function automatic logic [RXQ_CW-1:0] thr_level(input thr_sel_e sel);
        case (sel)
            THR_1:   thr_level = RXQ_CW'(1);
            THR_4:   thr_level = RXQ_CW'(4);
            THR_8:   thr_level = RXQ_CW'(8);
            default: thr_level = RXQ_CW'(14);
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 cap_one,
    input  logic                 push,
    input  logic [DW-1:0]        din,
    input  logic                 pop,
    output logic [DW-1:0]        dout,
    output logic [CW-1:0]        count,
    output rxq_pkg::rxq_move_t   move,
    output logic                 drop_q
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full         = cap_one ? (count != '0) : (count == CW'(DEPTH));
        move.pop_ok  = !flush && pop && (count != '0);
        move.push_ok = !flush && push && (!full || move.pop_ok);
        move.drop    = !flush && push && !move.push_ok;
    end

    always_ff @(posedge clk) begin
        if (move.push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= move.drop;
            if (move.push_ok) wr_ptr <= bump(wr_ptr);
            if (move.pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({move.push_ok, move.pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r4_single_cap: assert property (@(posedge clk) disable iff (rst)
        (cap_one && !flush && count <= CW'(1)) |=> count <= CW'(1));
    a_r5_drop_pulse: assert property (@(posedge clk) disable iff (rst)
        (move.drop) |=> drop_q);
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !push && !flush) |=> count == '0);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int  LIMIT = 4,
    localparam int TW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clear)                      ticks <= '0;
        else if (tick && ticks != TW'(LIMIT))  ticks <= ticks + TW'(1);
    end

    assign expired = (ticks == TW'(LIMIT));

    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        ticks <= TW'(LIMIT));
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clear |=> !expired);
endmodule

// File: rtl/uart_rx_fifo_trig.sv
module uart_rx_fifo_trig
    import rxq_pkg::*;
#(
    parameter int DEPTH      = RXQ_DEPTH,
    parameter int DW         = RXQ_DW,
    parameter int IDLE_CHARS = RXQ_IDLE_CHARS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_strobe,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    input  logic          char_tick,
    output logic [DW-1:0] rd_data,
    output logic          data_ready,
    output logic          trig_hit,
    output logic          timeout,
    output logic          overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          mode_q;
    logic          flush;
    logic [CW-1:0] count;
    rxq_move_t     move;
    logic          idle_clear;
    logic          idle_expired;
    logic          flags_on;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_en;
    end

    assign flush = (fifo_en != mode_q);

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .cap_one (!fifo_en),
        .push    (rx_valid),
        .din     (rx_data),
        .pop     (rd_strobe),
        .dout    (rd_data),
        .count   (count),
        .move    (move),
        .drop_q  (overrun)
    );

    assign idle_clear = flush || move.push_ok || move.pop_ok || (count == '0);

    rxq_idle_timer #(.LIMIT(IDLE_CHARS)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .clear   (idle_clear),
        .tick    (char_tick),
        .expired (idle_expired)
    );

    assign flags_on   = fifo_en && irq_en;
    assign data_ready = (count != '0);
    assign trig_hit   = flags_on && (count >= CW'(thr_level(thr_sel_e'(trig_sel))));
    assign timeout    = flags_on && idle_expired;

    a_r2_ready_from_store: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(rx_valid));
    a_r7_timeout_has_data: assert property (@(posedge clk) disable iff (rst)
        timeout |-> data_ready);
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !data_ready);
    a_r5_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(rx_valid));
endmodule

// File: tb/uart_rx_fifo_trig_tb.sv
module uart_rx_fifo_trig_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rd_strobe = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = '0;
    logic       irq_en = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, trig_hit, timeout, overrun;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    logic [7:0] mq[$];
    logic       m_mode = 1'b0;
    int         m_idle = 0;
    logic       m_ovr  = 1'b0;

    always #10 clk = ~clk;

    uart_rx_fifo_trig u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_strobe(rd_strobe), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .irq_en(irq_en), .char_tick(char_tick), .rd_data(rd_data),
        .data_ready(data_ready), .trig_hit(trig_hit), .timeout(timeout),
        .overrun(overrun)
    );

    function automatic int level_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model update for one cycle, then apply edge and compare
    task automatic step(input logic v, input logic [7:0] d, input logic r, input logic t);
        bit flush, pop_ok, push_ok, full;
        int cap;
        rx_valid = v; rx_data = d; rd_strobe = r; char_tick = t;
        flush = (fifo_en != m_mode);
        m_mode = fifo_en;
        if (flush) begin
            mq.delete(); m_idle = 0; m_ovr = 0;
        end else begin
            cap     = fifo_en ? 16 : 1;
            pop_ok  = r && mq.size() > 0;
            full    = (mq.size() >= cap);
            push_ok = v && (!full || pop_ok);
            if (pop_ok || push_ok || mq.size() == 0) m_idle = 0;
            else if (t && m_idle < 4) m_idle++;
            m_ovr = v && !push_ok;
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) mq.push_back(d);
        end
        @(posedge clk); #1;
        rx_valid = 0; rd_strobe = 0; char_tick = 0;
        chk("R2 data_ready", int'(data_ready), int'(mq.size() > 0));
        if (mq.size() > 0) chk("R3 rd_data order", int'(rd_data), int'(mq[0]));
        chk("R5 overrun", int'(overrun), int'(m_ovr));
        chk("R6/R8 trig_hit", int'(trig_hit),
            int'(fifo_en && irq_en && mq.size() >= level_of(trig_sel)));
        chk("R7/R8 timeout", int'(timeout), int'(fifo_en && irq_en && m_idle == 4));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 trig_hit", int'(trig_hit), 0);
        chk("R1 timeout", int'(timeout), 0);
        chk("R1 overrun", int'(overrun), 0);

        // R4 holding mode: second char dropped, first kept
        step(1, 8'hA1, 0, 0);
        step(1, 8'hB2, 0, 0);
        chk("R4 kept first", int'(rd_data), 8'hA1);
        step(0, 0, 1, 0);
        chk("R4 emptied", int'(data_ready), 0);
        // R10 read on empty ignored
        step(0, 0, 1, 0);
        chk("R10 empty read", int'(data_ready), 0);

        // R9 mode switch flushes
        step(1, 8'h33, 0, 0);
        fifo_en = 1; irq_en = 1;
        step(1, 8'h44, 0, 0);
        chk("R9 flush to fifo", int'(data_ready), 0);

        // R3/R5 fill to 16, then overflow
        for (int i = 0; i < 16; i++) step(1, 8'(i + 16), 0, 0);
        step(1, 8'hEE, 0, 0);
        chk("R5 overrun pulse", int'(overrun), 1);
        step(0, 0, 0, 0);
        chk("R5 overrun one cycle", int'(overrun), 0);
        // R10 push+pop on full
        step(1, 8'h77, 1, 0);
        chk("R10 full swap no overrun", int'(overrun), 0);

        // R6 threshold sweep
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            while (mq.size() > 0) step(0, 0, 1, 0);
            for (int k = 0; k < level_of(2'(s)); k++) step(1, 8'(k), 0, 0);
            chk("R6 at level", int'(trig_hit), 1);
            step(0, 0, 1, 0);
            chk("R6 below level", int'(trig_hit), 0);
        end

        // R7 timeout after exactly 4 ticks
        step(1, 8'h55, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1);
        chk("R7 not yet", int'(timeout), 0);
        step(0, 0, 0, 1);
        chk("R7 fired", int'(timeout), 1);
        step(1, 8'h56, 0, 0);
        chk("R7 cleared by store", int'(timeout), 0);
        // R8 polled gating
        for (int k = 0; k < 5; k++) step(0, 0, 0, 1);
        irq_en = 0;
        step(0, 0, 0, 0);
        chk("R8 polled timeout", int'(timeout), 0);
        chk("R8 polled trig", int'(trig_hit), 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 250 == 0) begin
                trig_sel = 2'($urandom_range(3));
                irq_en   = 1'($urandom_range(1));
            end
            if (i % 1500 == 1499) fifo_en = ~fifo_en;
            if ((i / 400) % 2 == 0)
                step(1'($urandom_range(3) != 0), 8'($urandom), 1'($urandom_range(3) == 0),
                     1'($urandom_range(1)));
            else
                step(1'($urandom_range(5) == 0), 8'($urandom), 1'($urandom_range(2) == 0),
                     1'($urandom_range(1)));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule